// File: doc/BRIEF.md
# Secure Memory Region Filter

This block sits on the request path between bus masters and a memory controller. Every read or write request carries an address and a security attribute (secure or non-secure). The filter checks each request against a set of programmable address windows. Each window has its own four permission bits: secure read, secure write, non-secure read and non-secure write. A permitted request passes through unchanged. A refused request is answered in one of two ways, chosen by an action register. In error mode it gets an error response. In benign mode it gets an okay response with zero data, and a refused write still reaches memory, but with no byte enabled. A refusal records the failing address and attributes and can latch an interrupt.

After reset the filter is bypassed and all traffic is forwarded. A level input asks for filtering. The change between bypass and filtering, in either direction, is made only when no transaction is outstanding, and the upstream side is stalled while the change is pending. Reads can be issued before the permission check completes. This speculative mode is on after reset; a speculative read that turns out to be refused has its returned data thrown away. One request is handled at a time. Responses come back in order and are always accepted.

Top module: `secmem_filter`

## Requirements
- R1: Window 0 is the background window. It covers every address and is always enabled, and its base and limit ignore writes. Its permission word is at offset 0x108 and resets to 0x8000000F. Bit 0 is secure read, bit 1 secure write, bit 2 non-secure read, bit 3 non-secure write, and bit 31 reads as the enable.
- R2: Windows 1..N-1 sit at 0x100+16*n. The base is at +0, the inclusive limit at +4, and the permissions at +8, with the enable at bit 31. Among the enabled windows that contain the address, the highest-numbered one sets the permissions. A disabled window has no effect.
- R3: In error mode, a refused read or write gets response code 2'b11 with zero data. When speculation does not apply, nothing is sent downstream.
- R4: In benign mode, a refused read gets response code 2'b00 with zero data, produced locally, and nothing is sent downstream.
- R5: In benign mode, a refused write is sent downstream with all strobes at 0 and data at 0. Its upstream response is 2'b00.
- R6: Offset 0x008 bit 0 set to 1 turns speculation off; it resets to 0. With speculation on and filtering active, a read is issued downstream at once, and its response appears 3 cycles after acceptance when memory answers in one cycle. With speculation off, or for any write, the check runs first and the same read takes 5 cycles.
- R7: When a speculative read is refused, the downstream data is discarded. The master receives the configured refusal response with zero data.
- R8: While bypassed, every request is forwarded unchanged with the memory's response. No violation is recorded and no interrupt is raised.
- R9: The filter takes at most one transaction at a time. A change of the filter-enable input takes effect only when nothing is outstanding. While that change waits, the ready signal is low. The filter_active output shows the current mode.
- R10: A refusal stores the address at 0x010 and the attributes at 0x014 (bit 0 write, bit 1 secure). If the interrupt is enabled, it also sets irq. irq stays high until any write to 0x00C; a new refusal in the same cycle wins over the clear.
- R11: The action register at 0x004 has bit 0 to select benign mode (1) or error mode (0), and bit 1 as the interrupt enable. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| bypass_off | input | 1 | 1 requests filtering, 0 requests bypass |
| filter_active | output | 1 | Current mode, 1 when filtering |
| up_valid | input | 1 | Master request valid |
| up_ready | output | 1 | Request accepted this cycle when high with up_valid |
| up_addr | input | ADDR_W | Request address |
| up_write | input | 1 | 1 for write |
| up_secure | input | 1 | 1 for a secure request |
| up_wdata | input | DATA_W | Write data |
| up_wstrb | input | DATA_W/8 | Byte strobes |
| up_rsp_valid | output | 1 | Response valid for one cycle |
| up_rsp_data | output | DATA_W | Read data |
| up_rsp_code | output | 2 | 2'b00 okay, 2'b11 decode error |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts |
| dn_addr | output | ADDR_W | Downstream address |
| dn_write | output | 1 | Downstream write flag |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_wstrb | output | DATA_W/8 | Downstream strobes |
| dn_rvalid | input | 1 | Memory response valid |
| dn_rdata | input | DATA_W | Memory read data |
| dn_resp | input | 2 | Memory response code |
| irq | output | 1 | Latched violation interrupt |

## Verification
A fixed table of twelve accesses mixes secure and non-secure reads and writes. It places them at the edges of two overlapping windows, inside a window that blocks everything, and in the background window. This separates the priority order, the inclusive bounds, the ignored disabled window and the per-attribute permission choice. Further accesses are run with the same address under the two refusal modes, with speculation on and off, and in bypass. The downstream counter tells local answers from forwarded ones, and the latency tells the checked path from the speculative path. An access kept in flight while filtering is requested shows that the mode waits for the transaction to finish.

// File: rtl/secmem_filter_pkg.sv
// Package: shared types and register offsets of the secure memory filter.
// Assumes a 32-bit register port.
package secmem_filter_pkg;

    localparam int REG_W         = 32;
    localparam int OFS_ACTION    = 'h004;
    localparam int OFS_SPEC      = 'h008;
    localparam int OFS_CLEAR     = 'h00C;
    localparam int OFS_FADDR     = 'h010;
    localparam int OFS_FATTR     = 'h014;
    localparam int OFS_WIN       = 'h100;
    localparam int WIN_STRIDE    = 16;

    localparam logic [1:0] RSP_OKAY   = 2'b00;
    localparam logic [1:0] RSP_DECERR = 2'b11;

    // Permission bit positions, index = {non_secure, write}
    localparam int PERM_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIT,
        ST_DECIDE,
        ST_ISSUE,
        ST_SPEC,
        ST_WAIT,
        ST_RESP
    } xfer_state_e;

endpackage

// File: rtl/secmem_regfile.sv
// Register file: action, speculation control, window configuration,
// violation capture and the latched interrupt.
// Assumes ADDR_W <= 32 and word-aligned register offsets.
module secmem_regfile
    import secmem_filter_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_REGIONS = 4,
    parameter int CFG_AW      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              viol_pulse,
    input  logic [ADDR_W-1:0] viol_addr,
    input  logic              viol_write,
    input  logic              viol_secure,
    output logic              okay_mode,
    output logic              irq_en,
    output logic              spec_off,
    output logic              irq,
    output logic [ADDR_W-1:0] win_base [NUM_REGIONS],
    output logic [ADDR_W-1:0] win_limit [NUM_REGIONS],
    output logic [PERM_W-1:0] win_perm [NUM_REGIONS],
    output logic              win_en [NUM_REGIONS]
);

    localparam logic [CFG_AW-1:0] A_ACTION = CFG_AW'(OFS_ACTION);
    localparam logic [CFG_AW-1:0] A_SPEC   = CFG_AW'(OFS_SPEC);
    localparam logic [CFG_AW-1:0] A_CLEAR  = CFG_AW'(OFS_CLEAR);
    localparam logic [CFG_AW-1:0] A_FADDR  = CFG_AW'(OFS_FADDR);
    localparam logic [CFG_AW-1:0] A_FATTR  = CFG_AW'(OFS_FATTR);

    function automatic logic [CFG_AW-1:0] win_ofs(input int idx, input int fld);
        return CFG_AW'(OFS_WIN + idx * WIN_STRIDE + fld * 4);
    endfunction

    logic [ADDR_W-1:0] fail_addr;
    logic              fail_wr;
    logic              fail_sec;
    logic              clr_hit;

    assign clr_hit = cfg_we && (cfg_addr == A_CLEAR);

    // Action and speculation control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            okay_mode <= 1'b0;
            irq_en    <= 1'b0;
            spec_off  <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr == A_ACTION) begin
                okay_mode <= cfg_wdata[0];
                irq_en    <= cfg_wdata[1];
            end
            if (cfg_addr == A_SPEC) begin
                spec_off <= cfg_wdata[0];
            end
        end
    end

    // Violation capture: address and attributes of the latest refusal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_addr <= '0;
            fail_wr   <= 1'b0;
            fail_sec  <= 1'b0;
        end else if (viol_pulse) begin
            fail_addr <= viol_addr;
            fail_wr   <= viol_write;
            fail_sec  <= viol_secure;
        end
    end

    // Interrupt latch: a new refusal wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (viol_pulse && irq_en) begin
            irq <= 1'b1;
        end else if (clr_hit) begin
            irq <= 1'b0;
        end
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
        if (g == 0) begin : g_bg
            logic [PERM_W-1:0] perm_r;
            // Background window permissions; its range is fixed to everything
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    perm_r <= '1;
                end else if (cfg_we && cfg_addr == win_ofs(g, 2)) begin
                    perm_r <= cfg_wdata[PERM_W-1:0];
                end
            end
            assign win_base[g]  = '0;
            assign win_limit[g] = '1;
            assign win_perm[g]  = perm_r;
            assign win_en[g]    = 1'b1;
        end else begin : g_prog
            logic [ADDR_W-1:0] base_r;
            logic [ADDR_W-1:0] limit_r;
            logic [PERM_W-1:0] perm_r;
            logic              en_r;
            // Programmable window: base, inclusive limit, permissions, enable
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    base_r  <= '0;
                    limit_r <= '0;
                    perm_r  <= '0;
                    en_r    <= 1'b0;
                end else if (cfg_we) begin
                    if (cfg_addr == win_ofs(g, 0)) base_r  <= cfg_wdata[ADDR_W-1:0];
                    if (cfg_addr == win_ofs(g, 1)) limit_r <= cfg_wdata[ADDR_W-1:0];
                    if (cfg_addr == win_ofs(g, 2)) begin
                        perm_r <= cfg_wdata[PERM_W-1:0];
                        en_r   <= cfg_wdata[REG_W-1];
                    end
                end
            end
            assign win_base[g]  = base_r;
            assign win_limit[g] = limit_r;
            assign win_perm[g]  = perm_r;
            assign win_en[g]    = en_r;
        end
    end

    // Read multiplexer over all registers
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == A_ACTION) cfg_rdata = REG_W'({irq_en, okay_mode});
        if (cfg_addr == A_SPEC)   cfg_rdata = REG_W'(spec_off);
        if (cfg_addr == A_FADDR)  cfg_rdata = REG_W'(fail_addr);
        if (cfg_addr == A_FATTR)  cfg_rdata = REG_W'({fail_sec, fail_wr});
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (cfg_addr == win_ofs(i, 0)) cfg_rdata = REG_W'(win_base[i]);
            if (cfg_addr == win_ofs(i, 1)) cfg_rdata = REG_W'(win_limit[i]);
            if (cfg_addr == win_ofs(i, 2)) begin
                cfg_rdata = {win_en[i], {(REG_W-PERM_W-1){1'b0}}, win_perm[i]};
            end
        end
    end

endmodule

// File: rtl/secmem_region_check.sv
// Window lookup: finds the highest-numbered enabled window holding the
// address and registers its permission bits (one cycle of latency).
// Assumes window 0 covers every address and is always enabled.
module secmem_region_check
    import secmem_filter_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_REGIONS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] win_base [NUM_REGIONS],
    input  logic [ADDR_W-1:0] win_limit [NUM_REGIONS],
    input  logic [PERM_W-1:0] win_perm [NUM_REGIONS],
    input  logic              win_en [NUM_REGIONS],
    output logic [PERM_W-1:0] perm_q
);

    logic [NUM_REGIONS-1:0] hit;
    logic [PERM_W-1:0]      perm_c;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        assign hit[g] = win_en[g] && (addr >= win_base[g]) && (addr <= win_limit[g]);
    end

    // Priority pick: later (higher-numbered) hits override earlier ones
    always_comb begin
        perm_c = win_perm[0];
        for (int i = 1; i < NUM_REGIONS; i++) begin
            if (hit[i]) perm_c = win_perm[i];
        end
    end

    // Register the verdict inputs to cut the compare path
    always_ff @(posedge clk) begin
        if (!rst_n) perm_q <= '0;
        else        perm_q <= perm_c;
    end

endmodule

// File: rtl/secmem_xfer_ctrl.sv
// Transfer controller: accepts one request at a time, sequences the check,
// forwarding, local answers and speculative reads, and moves the
// bypass/filter mode only while idle.
// Assumes the memory answers no earlier than the cycle after dn handshake
// and that responses are always accepted upstream.
module secmem_xfer_ctrl
    import secmem_filter_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass_off,
    output logic              filter_on,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic              up_write,
    input  logic              up_secure,
    input  logic [DATA_W-1:0] up_wdata,
    input  logic [STRB_W-1:0] up_wstrb,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_code,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [ADDR_W-1:0] dn_addr,
    output logic              dn_write,
    output logic [DATA_W-1:0] dn_wdata,
    output logic [STRB_W-1:0] dn_wstrb,
    input  logic              dn_rvalid,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic [1:0]        dn_resp,
    input  logic [PERM_W-1:0] perm_q,
    input  logic              okay_mode,
    input  logic              spec_off,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_write,
    output logic              req_secure,
    output logic              viol_pulse
);

    xfer_state_e       state;
    logic [DATA_W-1:0] r_wdata;
    logic [STRB_W-1:0] r_wstrb;
    logic              r_spec;
    logic              r_mask;
    logic              pend;
    logic              allow;
    logic              spec_deny;
    logic [1:0]        deny_code;

    assign pend      = bypass_off ^ filter_on;
    assign up_ready  = (state == ST_IDLE) && !pend;
    assign allow     = !filter_on || perm_q[{!req_secure, req_write}];
    assign spec_deny = r_spec && !allow;
    assign deny_code = okay_mode ? RSP_OKAY : RSP_DECERR;
    assign rsp_valid = (state == ST_RESP);
    assign dn_valid  = (state == ST_ISSUE) || (state == ST_SPEC);
    assign dn_addr   = req_addr;
    assign dn_write  = req_write;
    assign dn_wdata  = r_mask ? '0 : r_wdata;
    assign dn_wstrb  = r_mask ? '0 : r_wstrb;

    // One violation strobe per refused request, at the moment it is decided
    assign viol_pulse = ((state == ST_DECIDE) && !allow) ||
                        ((state == ST_WAIT) && dn_rvalid && spec_deny);

    // Main sequencer with request capture and mode handover
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            filter_on  <= 1'b0;
            req_addr   <= '0;
            req_write  <= 1'b0;
            req_secure <= 1'b0;
            r_wdata    <= '0;
            r_wstrb    <= '0;
            r_spec     <= 1'b0;
            r_mask     <= 1'b0;
            rsp_data   <= '0;
            rsp_code   <= RSP_OKAY;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (pend) begin
                        filter_on <= bypass_off;
                    end else if (up_valid) begin
                        req_addr   <= up_addr;
                        req_write  <= up_write;
                        req_secure <= up_secure;
                        r_wdata    <= up_wdata;
                        r_wstrb    <= up_wstrb;
                        r_mask     <= 1'b0;
                        r_spec     <= filter_on && !up_write && !spec_off;
                        state      <= (filter_on && !up_write && !spec_off) ? ST_SPEC : ST_HIT;
                    end
                end
                ST_HIT: begin
                    state <= ST_DECIDE;
                end
                ST_DECIDE: begin
                    if (allow) begin
                        state <= ST_ISSUE;
                    end else if (okay_mode && req_write) begin
                        r_mask <= 1'b1;
                        state  <= ST_ISSUE;
                    end else begin
                        rsp_data <= '0;
                        rsp_code <= deny_code;
                        state    <= ST_RESP;
                    end
                end
                ST_ISSUE, ST_SPEC: begin
                    if (dn_ready) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (dn_rvalid) begin
                        if (spec_deny) begin
                            rsp_data <= '0;
                            rsp_code <= deny_code;
                        end else if (r_mask) begin
                            rsp_data <= '0;
                            rsp_code <= RSP_OKAY;
                        end else begin
                            rsp_data <= dn_rdata;
                            rsp_code <= dn_resp;
                        end
                        state <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/secmem_filter.sv
// Top: secure memory region filter. Connects the register file, the
// window lookup and the transfer controller.
// Assumes a single request path with in-order, always-accepted responses.
module secmem_filter
    import secmem_filter_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int NUM_REGIONS = 4,
    parameter int CFG_AW      = 12,
    localparam int STRB_W     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              bypass_off,
    output logic              filter_active,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic              up_write,
    input  logic              up_secure,
    input  logic [DATA_W-1:0] up_wdata,
    input  logic [STRB_W-1:0] up_wstrb,
    output logic              up_rsp_valid,
    output logic [DATA_W-1:0] up_rsp_data,
    output logic [1:0]        up_rsp_code,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [ADDR_W-1:0] dn_addr,
    output logic              dn_write,
    output logic [DATA_W-1:0] dn_wdata,
    output logic [STRB_W-1:0] dn_wstrb,
    input  logic              dn_rvalid,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic [1:0]        dn_resp,
    output logic              irq
);

    logic [ADDR_W-1:0] win_base [NUM_REGIONS];
    logic [ADDR_W-1:0] win_limit [NUM_REGIONS];
    logic [PERM_W-1:0] win_perm [NUM_REGIONS];
    logic              win_en [NUM_REGIONS];
    logic [PERM_W-1:0] perm_q;
    logic              okay_mode_w;
    logic              irq_en_w;
    logic              spec_off_w;
    logic [ADDR_W-1:0] req_addr;
    logic              req_write;
    logic              req_secure;
    logic              viol_pulse;

    secmem_regfile #(
        .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .CFG_AW(CFG_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .viol_pulse(viol_pulse), .viol_addr(req_addr),
        .viol_write(req_write), .viol_secure(req_secure),
        .okay_mode(okay_mode_w), .irq_en(irq_en_w), .spec_off(spec_off_w), .irq(irq),
        .win_base(win_base), .win_limit(win_limit), .win_perm(win_perm), .win_en(win_en)
    );

    secmem_region_check #(
        .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS)
    ) u_check (
        .clk(clk), .rst_n(rst_n), .addr(req_addr),
        .win_base(win_base), .win_limit(win_limit), .win_perm(win_perm), .win_en(win_en),
        .perm_q(perm_q)
    );

    secmem_xfer_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .bypass_off(bypass_off), .filter_on(filter_active),
        .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
        .up_write(up_write), .up_secure(up_secure), .up_wdata(up_wdata), .up_wstrb(up_wstrb),
        .rsp_valid(up_rsp_valid), .rsp_data(up_rsp_data), .rsp_code(up_rsp_code),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_write(dn_write),
        .dn_wdata(dn_wdata), .dn_wstrb(dn_wstrb),
        .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata), .dn_resp(dn_resp),
        .perm_q(perm_q), .okay_mode(okay_mode_w), .spec_off(spec_off_w),
        .req_addr(req_addr), .req_write(req_write), .req_secure(req_secure),
        .viol_pulse(viol_pulse)
    );

endmodule

// File: rtl/secmem_filter_chk.sv
// Checker: protocol and mode-handover properties of the filter, observed
// at its ports plus the interrupt enable. Tracks occupancy by itself.
module secmem_filter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        up_valid,
    input logic        up_ready,
    input logic        up_rsp_valid,
    input logic [1:0]  up_rsp_code,
    input logic [31:0] up_rsp_data,
    input logic        dn_valid,
    input logic        bypass_off,
    input logic        filter_active,
    input logic        irq,
    input logic        irq_en
);

    logic inflight;

    // Occupancy: set on acceptance, cleared after the response cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                    inflight <= 1'b0;
        else if (up_valid && up_ready) inflight <= 1'b1;
        else if (up_rsp_valid)         inflight <= 1'b0;
    end

    assert_single_txn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready) |-> !inflight);

    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inflight |=> $stable(filter_active));

    assert_stall_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_off != filter_active) |-> !up_ready);

    assert_rsp_in_txn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        up_rsp_valid |-> inflight);

    assert_dn_in_txn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> inflight);

    assert_decerr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid && up_rsp_code == 2'b11) |-> (up_rsp_data == 32'h0));

    assert_irq_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_en));

    assert_bypass_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(filter_active));

endmodule

bind secmem_filter secmem_filter_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .up_valid(up_valid), .up_ready(up_ready),
    .up_rsp_valid(up_rsp_valid), .up_rsp_code(up_rsp_code), .up_rsp_data(up_rsp_data),
    .dn_valid(dn_valid), .bypass_off(bypass_off), .filter_active(filter_active),
    .irq(irq), .irq_en(irq_en_w)
);

// File: tb/secmem_filter_test.sv
module secmem_filter_test;

    localparam logic [31:0] MAGIC = 32'hA5A5_0000;

    typedef struct packed {
        logic        wr;
        logic        sec;
        logic [31:0] addr;
        logic [1:0]  rc;
        logic        fwd;
    } vec_t;

    // Windows: 0 = secure only; 1 = 0x1000..0x1FFF ns read; 2 = 0x1800..0x18FF none;
    // 3 disabled with all permissions. Error mode, speculation off.
    localparam vec_t VECS [12] = '{
        '{1'b0, 1'b1, 32'h0000_0100, 2'b00, 1'b1},
        '{1'b1, 1'b1, 32'h0000_0100, 2'b00, 1'b1},
        '{1'b0, 1'b0, 32'h0000_0100, 2'b11, 1'b0},
        '{1'b1, 1'b0, 32'h0000_0100, 2'b11, 1'b0},
        '{1'b0, 1'b0, 32'h0000_1000, 2'b00, 1'b1},
        '{1'b0, 1'b1, 32'h0000_1FFF, 2'b11, 1'b0},
        '{1'b0, 1'b0, 32'h0000_17FF, 2'b00, 1'b1},
        '{1'b0, 1'b0, 32'h0000_1800, 2'b11, 1'b0},
        '{1'b0, 1'b0, 32'h0000_18FF, 2'b11, 1'b0},
        '{1'b0, 1'b0, 32'h0000_1900, 2'b00, 1'b1},
        '{1'b1, 1'b0, 32'h0000_1000, 2'b11, 1'b0},
        '{1'b0, 1'b1, 32'h0000_2000, 2'b00, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bypass_off = 1'b0;
    logic        filter_active;
    logic        up_valid = 1'b0;
    logic        up_ready;
    logic [31:0] up_addr = '0;
    logic        up_write = 1'b0;
    logic        up_secure = 1'b0;
    logic [31:0] up_wdata = '0;
    logic [3:0]  up_wstrb = '0;
    logic        up_rsp_valid;
    logic [31:0] up_rsp_data;
    logic [1:0]  up_rsp_code;
    logic        dn_valid;
    logic        dn_ready = 1'b1;
    logic [31:0] dn_addr;
    logic        dn_write;
    logic [31:0] dn_wdata;
    logic [3:0]  dn_wstrb;
    logic        dn_rvalid;
    logic [31:0] dn_rdata;
    logic [1:0]  dn_resp;
    logic        irq;

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    int          dn_count;
    logic [31:0] last_dn_addr;
    logic [31:0] last_dn_wdata;
    logic [3:0]  last_dn_wstrb;

    always #10 clk = ~clk;

    secmem_filter uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bypass_off(bypass_off), .filter_active(filter_active),
        .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
        .up_write(up_write), .up_secure(up_secure), .up_wdata(up_wdata), .up_wstrb(up_wstrb),
        .up_rsp_valid(up_rsp_valid), .up_rsp_data(up_rsp_data), .up_rsp_code(up_rsp_code),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_write(dn_write),
        .dn_wdata(dn_wdata), .dn_wstrb(dn_wstrb),
        .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata), .dn_resp(dn_resp),
        .irq(irq)
    );

    // Memory model: answers one cycle after each accepted request
    always @(posedge clk) begin
        if (!rst_n) begin
            dn_rvalid <= 1'b0;
            dn_rdata  <= '0;
            dn_resp   <= 2'b00;
            dn_count  <= 0;
        end else begin
            dn_rvalid <= dn_valid && dn_ready;
            if (dn_valid && dn_ready) begin
                dn_rdata      <= dn_write ? 32'h0 : (dn_addr ^ MAGIC);
                dn_count      <= dn_count + 1;
                last_dn_addr  <= dn_addr;
                last_dn_wdata <= dn_wdata;
                last_dn_wstrb <= dn_wstrb;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic xfer(input logic wr, input logic sec, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] s, input logic flip,
                        output logic [1:0] rc, output logic [31:0] rd, output int lat);
        @(negedge clk);
        up_valid = 1'b1; up_write = wr; up_secure = sec;
        up_addr = a; up_wdata = d; up_wstrb = s;
        #1;
        while (!up_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        up_valid = 1'b0;
        if (flip) bypass_off = 1'b1;
        lat = 1;
        while (!up_rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        rc = up_rsp_code;
        rd = up_rsp_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual hang expected finish");
        finish_run();
    end

    initial begin
        logic [1:0]  rc;
        logic [31:0] rd;
        logic [31:0] rv;
        int          lat;
        int          cnt0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R1, R6, R9, R10, R11)
        @(negedge clk);
        check("R9 filter_active after reset", 32'(filter_active), 32'h0);
        check("R9 up_ready after reset", 32'(up_ready), 32'h1);
        check("R10 irq after reset", 32'(irq), 32'h0);
        reg_rd(12'h108, rv); check("R1 background perm reset", rv, 32'h8000_000F);
        reg_rd(12'h004, rv); check("R11 action reset", rv, 32'h0);
        reg_rd(12'h008, rv); check("R6 speculation control reset", rv, 32'h0);
        reg_wr(12'h100, 32'h0000_4000);
        reg_wr(12'h104, 32'h0000_5000);
        reg_rd(12'h104, rv); check("R1 background limit ignores writes", rv, 32'hFFFF_FFFF);

        // Bypass: everything forwarded even with all permissions cleared (R8)
        reg_wr(12'h108, 32'h0);
        reg_wr(12'h004, 32'h2);
        reg_rd(12'h004, rv); check("R11 action readback", rv, 32'h2);
        cnt0 = dn_count;
        xfer(1'b1, 1'b0, 32'h0000_0040, 32'h1234_5678, 4'h5, 1'b0, rc, rd, lat);
        check("R8 bypass write forwarded", 32'(dn_count - cnt0), 32'h1);
        check("R8 bypass write data", last_dn_wdata, 32'h1234_5678);
        check("R8 bypass write strobes", 32'(last_dn_wstrb), 32'h5);
        check("R8 bypass response", 32'(rc), 32'h0);
        check("R8 bypass no irq", 32'(irq), 32'h0);

        // Handover requested while a read is in flight (R9)
        cnt0 = dn_count;
        xfer(1'b0, 1'b0, 32'h0000_0080, 32'h0, 4'h0, 1'b1, rc, rd, lat);
        check("R8 bypass read data", rd, 32'h0000_0080 ^ MAGIC);
        check("R9 mode unchanged at response", 32'(filter_active), 32'h0);
        @(negedge clk);
        check("R9 ready low while handover pending", 32'(up_ready), 32'h0);
        @(negedge clk);
        check("R9 filter active after idle", 32'(filter_active), 32'h1);
        check("R9 ready back after handover", 32'(up_ready), 32'h1);

        // Window setup for the table (R2)
        reg_wr(12'h108, 32'h3);
        reg_wr(12'h110, 32'h0000_1000);
        reg_wr(12'h114, 32'h0000_1FFF);
        reg_wr(12'h118, 32'h8000_0004);
        reg_wr(12'h120, 32'h0000_1800);
        reg_wr(12'h124, 32'h0000_18FF);
        reg_wr(12'h128, 32'h8000_0000);
        reg_wr(12'h130, 32'h0);
        reg_wr(12'h134, 32'hFFFF_FFFF);
        reg_wr(12'h138, 32'h0000_000F);
        reg_wr(12'h008, 32'h1);
        reg_rd(12'h118, rv); check("R2 window permission readback", rv, 32'h8000_0004);

        // Table walk: priority, bounds, permissions, error mode (R2, R3)
        for (int i = 0; i < 12; i++) begin
            logic [31:0] exp_d;
            cnt0  = dn_count;
            exp_d = (VECS[i].fwd && !VECS[i].wr) ? (VECS[i].addr ^ MAGIC) : 32'h0;
            xfer(VECS[i].wr, VECS[i].sec, VECS[i].addr, 32'hC0DE_0000 | 32'(i), 4'hF,
                 1'b0, rc, rd, lat);
            check($sformatf("R2 R3 vec %0d response", i), 32'(rc), 32'(VECS[i].rc));
            check($sformatf("R2 R3 vec %0d data", i), rd, exp_d);
            check($sformatf("R2 R3 vec %0d forwarded", i), 32'(dn_count - cnt0), 32'(VECS[i].fwd));
        end

        // Capture and interrupt (R10)
        check("R10 irq set by refusals", 32'(irq), 32'h1);
        reg_rd(12'h010, rv); check("R10 failing address", rv, 32'h0000_1000);
        reg_rd(12'h014, rv); check("R10 failing attributes", rv, 32'h1);
        reg_wr(12'h00C, 32'h0);
        check("R10 irq cleared", 32'(irq), 32'h0);

        // Checked-first latency (R6)
        xfer(1'b0, 1'b1, 32'h0000_0300, 32'h0, 4'h0, 1'b0, rc, rd, lat);
        check("R6 checked read latency", 32'(lat), 32'd5);

        // Benign mode, interrupt disabled (R4, R5, R11)
        reg_wr(12'h004, 32'h1);
        cnt0 = dn_count;
        xfer(1'b0, 1'b0, 32'h0000_0100, 32'h0, 4'h0, 1'b0, rc, rd, lat);
        check("R4 benign read response", 32'(rc), 32'h0);
        check("R4 benign read data", rd, 32'h0);
        check("R4 benign read not forwarded", 32'(dn_count - cnt0), 32'h0);
        check("R11 no irq when disabled", 32'(irq), 32'h0);
        reg_rd(12'h010, rv); check("R10 capture without irq", rv, 32'h0000_0100);
        cnt0 = dn_count;
        xfer(1'b1, 1'b0, 32'h0000_0104, 32'hDEAD_BEEF, 4'hF, 1'b0, rc, rd, lat);
        check("R5 benign write forwarded", 32'(dn_count - cnt0), 32'h1);
        check("R5 benign write strobes", 32'(last_dn_wstrb), 32'h0);
        check("R5 benign write data", last_dn_wdata, 32'h0);
        check("R5 benign write address", last_dn_addr, 32'h0000_0104);
        check("R5 benign write response", 32'(rc), 32'h0);

        // Speculation on (R6, R7)
        reg_wr(12'h008, 32'h0);
        cnt0 = dn_count;
        xfer(1'b0, 1'b1, 32'h0000_0200, 32'h0, 4'h0, 1'b0, rc, rd, lat);
        check("R6 speculative read latency", 32'(lat), 32'd3);
        check("R6 speculative read data", rd, 32'h0000_0200 ^ MAGIC);
        cnt0 = dn_count;
        xfer(1'b0, 1'b0, 32'h0000_0100, 32'h0, 4'h0, 1'b0, rc, rd, lat);
        check("R7 speculative refused read went downstream", 32'(dn_count - cnt0), 32'h1);
        check("R7 benign replacement code", 32'(rc), 32'h0);
        check("R7 benign replacement data", rd, 32'h0);
        reg_wr(12'h004, 32'h2);
        xfer(1'b0, 1'b0, 32'h0000_0100, 32'h0, 4'h0, 1'b0, rc, rd, lat);
        check("R7 error replacement code", 32'(rc), 32'h3);
        check("R7 error replacement data", rd, 32'h0);
        check("R10 irq from speculative refusal", 32'(irq), 32'h1);

        finish_run();
    end

endmodule